// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Register Master

This block is a hardware master for the four-wire serial port of a multi-channel delta-sigma converter. It drives an active-low chip select, a serial clock, and the converter's data input, and it samples the converter's data output. It can send a command byte on its own, write a 24-bit register (command byte plus three data bytes), read a 24-bit register (command byte out, then 24 bits in), and send a resynchronisation burst that puts the converter's port back into the state where it waits for a command.

A client starts a transfer by pulsing a start input together with a transfer kind, a command byte and a write word. The block raises busy, runs the transfer, and ends it with a one-cycle done strobe. For reads it also updates a read-data word. After reset the block waits a programmable number of cycles so the converter's oscillator can start, then sends one resynchronisation burst by itself. The serial clock comes from the system clock through a divider. The divider is clamped so that the serial clock never goes above 2 MHz, whatever system clock frequency is configured.

Top module: `adc_serial_master`

## Requirements
- R1: While cs_n is high, sclk is low. The master changes mosi only while sclk is low and samples miso on the rising edge of sclk (clock idles low, data centred on the rising edge).
- R2: Every byte is shifted most significant bit first, on mosi and on miso.
- R3: A resynchronisation (kind 2'b11) gives exactly 128 sclk rising edges. The bits are fifteen 0xFF bytes followed by one 0xFE byte, so 127 ones and then a single zero.
- R4: A register write (kind 2'b01) gives exactly 32 rising edges. The bits are the command byte followed by the 24-bit write word.
- R5: A register read (kind 2'b10) gives exactly 32 rising edges. The first 8 carry the command byte, and mosi is held low for the remaining 24. rd_data holds the 24 bits captured from miso, with the first captured bit as bit 23. rd_data is updated only when a read completes.
- R6: A command-only transfer (kind 2'b00) gives exactly 8 rising edges carrying the command byte.
- R7: Each sclk half-period lasts HALF = max(HALF_DIV, ceil(CLK_HZ / (2 * SCLK_MAX_HZ))) system cycles, so with the defaults consecutive rising edges are 64 cycles apart.
- R8: cs_n stays low for the whole transfer. At least HALF cycles pass between the falling edge of cs_n and the first sclk rise, and between the last sclk fall and the rise of cs_n.
- R9: A start is accepted only when busy is low. Busy is high from the cycle after acceptance until the cycle in which done pulses high for one cycle. A start pulsed while busy changes neither the transfer in flight nor anything after it.
- R10: After reset, busy is high, cs_n is high and sclk is low. After POWERUP_CYCLES cycles the master sends one resynchronisation burst on its own and ends it with a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | One-cycle request to start a transfer |
| req_kind | input | 2 | 00 command only, 01 write, 10 read, 11 resynchronise |
| req_cmd | input | 8 | Command byte |
| req_wdata | input | 24 | Write data word |
| busy | output | 1 | Transfer or power-up wait in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |
| rd_data | output | 24 | Last word read from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Data to the converter |
| miso | input | 1 | Data from the converter |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a transfer. It must be dropped completely: it must not corrupt the frame in flight and it must not start a second transfer afterwards. The bench pulses start with a different kind halfway through a write. It then checks the captured frame, checks that rd_data is unchanged, and confirms that cs_n stays high for a long quiet window after done. The bench also sweeps command and data patterns across all four transfer kinds against a bench-side converter model that shifts out a known word. The power-up burst is checked by measuring its delay from reset and decoding its bytes.

// File: rtl/adcm_pkg.sv
// Shared types for the converter serial master.
// Assumes: transfer kind encoding is fixed by the request interface.
package adcm_pkg;
    typedef enum logic [1:0] {
        KIND_CMD  = 2'b00,
        KIND_WR   = 2'b01,
        KIND_RD   = 2'b10,
        KIND_SYNC = 2'b11
    } xfer_kind_t;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_IDLE,
        ST_LEAD,
        ST_BITS,
        ST_TRAIL
    } seq_state_t;
endpackage

// File: rtl/adcm_halfclk.sv
// Half-period tick generator for the serial clock.
// Emits one tick every HALF cycles while run is high and restarts its count
// whenever run is low, so the first tick comes HALF cycles after run rises.
module adcm_halfclk #(
    parameter int HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(HALF + 1);

    logic [CNT_W-1:0] cnt;

    // Count system cycles within one half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)                  cnt <= '0;
        else if (cnt == CNT_W'(HALF - 1))    cnt <= '0;
        else                                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == CNT_W'(HALF - 1));

    generate
        if (HALF > 1) begin : g_spacing
            a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/adcm_shift.sv
// Transmit and receive shift registers for one frame.
// Assumes: load and shift_en are never high together. The receive word holds
// its value while cap_en is low.
module adcm_shift #(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [CMD_W+DATA_W-1:0]   load_word,
    input  logic                      shift_en,
    input  logic                      cap_en,
    input  logic                      miso,
    output logic                      tx_bit,
    output logic [DATA_W-1:0]         rx_word
);
    localparam int FRAME_W = CMD_W + DATA_W;

    logic [FRAME_W-1:0] tx_q;

    // Load a frame, then move it out MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_q <= '0;
        else if (load)     tx_q <= load_word;
        else if (shift_en) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end

    // Collect receive bits MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_word <= '0;
        else if (cap_en) rx_word <= {rx_word[DATA_W-2:0], miso};
    end

    assign tx_bit = tx_q[FRAME_W-1];

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift_en));
endmodule

// File: rtl/adc_serial_master.sv
// Serial master for a delta-sigma converter's four-wire port.
// Runs command-only, register write, register read and resync transfers.
// Assumes: the converter samples on the rising edge of sclk and drives miso
// after the falling edge. POWERUP_CYCLES >= 1.
module adc_serial_master #(
    parameter int CLK_HZ         = 125_000_000,
    parameter int SCLK_MAX_HZ    = 2_000_000,
    parameter int HALF_DIV       = 4,
    parameter int POWERUP_CYCLES = 100,
    parameter int CMD_W          = 8,
    parameter int DATA_W         = 24,
    parameter int SYNC_BYTES     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [1:0]        req_kind,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    import adcm_pkg::*;

    localparam int MIN_HALF  = (CLK_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
    localparam int HALF      = (HALF_DIV > MIN_HALF) ? HALF_DIV : MIN_HALF;
    localparam int FRAME_W   = CMD_W + DATA_W;
    localparam int SYNC_BITS = 8 * SYNC_BYTES;
    localparam int MAX_BITS  = (SYNC_BITS > FRAME_W) ? SYNC_BITS : FRAME_W;
    localparam int IDX_W     = $clog2(MAX_BITS);
    localparam int PWR_W     = $clog2(POWERUP_CYCLES + 1);

    seq_state_t        state;
    xfer_kind_t        kind_q;
    logic [IDX_W-1:0]  bit_idx, last_idx;
    logic [PWR_W-1:0]  pwr_cnt;
    logic              run, tick, rising, shift_en, cap_en, load, tx_bit;
    logic [DATA_W-1:0] rx_word;
    xfer_kind_t        req_k;

    assign req_k    = xfer_kind_t'(req_kind);
    assign run      = (state == ST_LEAD) || (state == ST_BITS) || (state == ST_TRAIL);
    assign rising   = tick && ((state == ST_LEAD) || (state == ST_BITS && !sclk));
    assign shift_en = tick && state == ST_BITS && sclk && bit_idx != last_idx;
    assign cap_en   = rising && kind_q == KIND_RD && bit_idx >= IDX_W'(CMD_W);
    assign load     = state == ST_IDLE && req_start;
    assign busy     = state != ST_IDLE;

    adcm_halfclk #(.HALF(HALF)) u_half (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    adcm_shift #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_word({req_cmd, (req_k == KIND_WR) ? req_wdata : {DATA_W{1'b0}}}),
        .shift_en(shift_en), .cap_en(cap_en), .miso(miso),
        .tx_bit(tx_bit), .rx_word(rx_word)
    );

    // Transfer sequencer: power-up wait, guard phases, bit clocking, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT;
            kind_q   <= KIND_SYNC;
            bit_idx  <= '0;
            last_idx <= '0;
            pwr_cnt  <= '0;
            sclk     <= 1'b0;
            cs_n     <= 1'b1;
            done     <= 1'b0;
            rd_data  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_WAIT: begin
                    pwr_cnt <= pwr_cnt + 1'b1;
                    if (pwr_cnt == PWR_W'(POWERUP_CYCLES - 1)) begin
                        state    <= ST_LEAD;
                        kind_q   <= KIND_SYNC;
                        bit_idx  <= '0;
                        last_idx <= IDX_W'(SYNC_BITS - 1);
                        cs_n     <= 1'b0;
                    end
                end
                ST_IDLE: begin
                    if (req_start) begin
                        state   <= ST_LEAD;
                        kind_q  <= req_k;
                        bit_idx <= '0;
                        cs_n    <= 1'b0;
                        case (req_k)
                            KIND_CMD:  last_idx <= IDX_W'(CMD_W - 1);
                            KIND_SYNC: last_idx <= IDX_W'(SYNC_BITS - 1);
                            default:   last_idx <= IDX_W'(FRAME_W - 1);
                        endcase
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        state <= ST_BITS;
                    end
                end
                ST_BITS: begin
                    if (tick) begin
                        sclk <= !sclk;
                        if (sclk) begin
                            if (bit_idx == last_idx) state <= ST_TRAIL;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        cs_n  <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                        if (kind_q == KIND_RD) rd_data <= rx_word;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output bit select: resync pattern or frame shifter, low when deselected.
    always_comb begin
        if (cs_n)                     mosi = 1'b0;
        else if (kind_q == KIND_SYNC) mosi = (bit_idx != IDX_W'(SYNC_BITS - 1));
        else                          mosi = tx_bit;
    end

    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    a_r1_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !tick) |=> $stable(mosi));
    a_r7_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sclk));
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n));
    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_start) |=> (busy && !cs_n));
    a_r10_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (cs_n && !done));
endmodule

// File: tb/test_adc_serial_master.sv
`timescale 1ns/1ps
module test_adc_serial_master;
    localparam int HALF = (125_000_000 + 4_000_000 - 1) / 4_000_000;
    localparam int PWR  = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [7:0]  req_cmd = 8'h00;
    logic [23:0] req_wdata = 24'h0;
    logic        busy, done, cs_n, sclk, mosi, miso;
    logic [23:0] rd_data;

    int checks = 0, failures = 0;
    int cyc = 0, t_csf = 0, t_rise = 0, t_fall = 0, t_rst = 0, nrise = 0;
    bit per_bad = 0, guard_bad = 0, idle_bad = 0, prev_sclk = 0, prev_cs = 1;
    logic [127:0] log_bits = '0;
    logic [23:0]  slave_word = 24'h0, sw = 24'h0;

    always #4 clk = ~clk;

    adc_serial_master i_adc_serial_master (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_kind(req_kind),
        .req_cmd(req_cmd), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    assign miso = (nrise >= 8 && nrise < 32) ? sw[23] : 1'b0;

    // Bus monitor and converter model, sampled away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_cs && !cs_n) begin
            nrise = 0; log_bits = '0; t_csf = cyc;
            per_bad = 0; guard_bad = 0; sw = slave_word;
        end
        if (!prev_sclk && sclk) begin
            if (nrise == 0) begin
                if (cyc - t_csf < HALF) guard_bad = 1;
            end else if (cyc - t_rise != 2*HALF) per_bad = 1;
            t_rise = cyc;
            log_bits = {log_bits[126:0], mosi};
            nrise = nrise + 1;
        end
        if (prev_sclk && !sclk) begin
            t_fall = cyc;
            if (nrise >= 9) sw = {sw[22:0], 1'b0};
        end
        if (!prev_cs && cs_n && (cyc - t_fall < HALF)) guard_bad = 1;
        if (cs_n && sclk) idle_bad = 1;
        prev_sclk = sclk;
        prev_cs = cs_n;
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        do begin
            @(negedge clk); #1;
        end while (!done);
    endtask

    task automatic run(input logic [1:0] k, input logic [7:0] c, input logic [23:0] d);
        @(negedge clk);
        req_kind = k; req_cmd = c; req_wdata = d; req_start = 1'b1;
        @(negedge clk); #1;
        req_start = 1'b0;
        chk(busy === 1'b1, "R9 busy after start", 128'(busy), 128'd1);
        wait_done();
        chk(busy === 1'b0, "R9 busy low at done", 128'(busy), 128'd0);
    endtask

    task automatic chk_timing(input string tag);
        chk(!per_bad, {"R7 sclk period ", tag}, 128'(per_bad), 128'd0);
        chk(!guard_bad, {"R8 cs guard ", tag}, 128'(guard_bad), 128'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures = failures + 1;
        $display("FAIL watchdog R9 act=hang exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        chk(cs_n === 1'b1 && sclk === 1'b0, "R10 reset lines", {cs_n, sclk}, 2'b10);
        chk(busy === 1'b1 && done === 1'b0, "R10 reset busy", {busy, done}, 2'b10);
        @(negedge clk);
        rst_n = 1'b1;
        t_rst = cyc + 1;
        // R10 automatic resync after power-up delay, R3 pattern
        wait_done();
        chk((t_csf - t_rst) >= PWR && (t_csf - t_rst) <= PWR + 1, "R10 powerup delay",
            128'(t_csf - t_rst), 128'(PWR));
        chk(nrise == 128, "R3 resync clocks", 128'(nrise), 128'd128);
        chk(log_bits == {{15{8'hFF}}, 8'hFE}, "R3 resync bytes", log_bits,
            {{15{8'hFF}}, 8'hFE});
        chk_timing("sync");
        // R4 write sweep, R2 MSB first
        for (int i = 0; i < 5; i++) begin
            logic [7:0]  c = 8'(8'h01 << i) ^ 8'h03;
            logic [23:0] d = 24'(24'h800001 >> i) ^ 24'(i * 24'h0F0F11);
            run(2'b01, c, d);
            chk(nrise == 32, "R4 write clocks", 128'(nrise), 128'd32);
            chk(log_bits[31:0] == {c, d}, "R4 R2 write frame", 128'(log_bits[31:0]),
                128'({c, d}));
            chk_timing("write");
        end
        // R5 read sweep
        for (int i = 0; i < 4; i++) begin
            logic [7:0] c = 8'h0A + 8'(i);
            slave_word = 24'(24'hA5C3F1 ^ (i * 24'h111111));
            run(2'b10, c, 24'hFFFFFF);
            chk(nrise == 32, "R5 read clocks", 128'(nrise), 128'd32);
            chk(log_bits[31:0] == {c, 24'h0}, "R5 read mosi", 128'(log_bits[31:0]),
                128'({c, 24'h0}));
            chk(rd_data == slave_word, "R5 R2 read data", 128'(rd_data), 128'(slave_word));
            chk_timing("read");
        end
        // R6 command only
        for (int i = 0; i < 3; i++) begin
            logic [7:0] c = 8'h81 ^ 8'(i * 8'h27);
            run(2'b00, c, 24'h123456);
            chk(nrise == 8, "R6 cmd clocks", 128'(nrise), 128'd8);
            chk(log_bits[7:0] == c, "R6 cmd byte", 128'(log_bits[7:0]), 128'(c));
            chk(rd_data == slave_word, "R5 rd_data kept on non-read", 128'(rd_data),
                128'(slave_word));
        end
        // R3 requested resync
        run(2'b11, 8'h00, 24'h0);
        chk(log_bits == {{15{8'hFF}}, 8'hFE}, "R3 requested resync", log_bits,
            {{15{8'hFF}}, 8'hFE});
        // R9 start while busy is ignored
        @(negedge clk);
        req_kind = 2'b01; req_cmd = 8'h03; req_wdata = 24'h5A5A5A; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        repeat (20 * HALF) @(negedge clk);
        req_kind = 2'b10; req_cmd = 8'h0B; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_done();
        chk(nrise == 32 && log_bits[31:0] == {8'h03, 24'h5A5A5A}, "R9 frame intact",
            128'(log_bits[31:0]), 128'({8'h03, 24'h5A5A5A}));
        chk(rd_data == slave_word, "R9 no read result", 128'(rd_data), 128'(slave_word));
        @(negedge clk); #1;
        chk(done === 1'b0, "R9 done one cycle", 128'(done), 128'd0);
        begin
            bit quiet = 1;
            for (int j = 0; j < 4 * HALF; j++) begin
                @(negedge clk); #1;
                if (cs_n !== 1'b1 || busy !== 1'b0) quiet = 0;
            end
            chk(quiet, "R9 no late transfer", 128'(quiet), 128'd1);
        end
        chk(!idle_bad, "R1 sclk low while deselected", 128'(idle_bad), 128'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule